// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Late Write

This block models a single-port static RAM in which both the inputs and the outputs are registered. It runs on one rising-edge clock. A command is formed from an active-low select and an active-low write enable, and it is captured together with the address and the active-low byte-lane enables. A read returns its word from the output register one clock after the command edge. A deselect uses the same pipeline, so the outputs go quiet one clock after a deselect, not right away.

Writes are late. The command edge captures the address and the lane mask. The data bus is sampled on the following edge, and the array is updated on that same edge. An active-low output enable gates the data outputs, which are modelled as a data bus, an output-valid flag and a tri-state enable. An active-high sleep input drops new commands and turns the outputs off. The stored contents are kept during sleep.

The depth and the lane width and count are parameters. The default is 1024 words of two 9-bit lanes, which gives 18 bits.

Top module: `pipe_sram`

## Requirements
- R1: While reset is asserted, and after it is released with no command issued, dout_vld, dout_en and dout are all zero.
- R2: A read command is sel_n=0 and we_n=1 with sleep=0, sampled at rising edge N. After edge N+1 (and not before), dout_vld=1 and the output register holds the word stored at the captured address.
- R3: A deselect command is sel_n=1, sampled at edge N. Between edges N and N+1 the outputs still show the result of the previous command. After edge N+1, dout_vld=0.
- R4: dout_en is 1 exactly when dout_vld=1 and oe_n=0. In that case dout shows the output register. Otherwise dout reads as all zeros, which models high impedance.
- R5: A write command is sel_n=0 and we_n=0, sampled at edge N. It captures the address and bw_n at edge N. It then samples din at edge N+1 and writes the array at edge N+1.
- R6: Bit i of bw_n is active low and enables lane i, which is bits 9*i+8 down to 9*i of the word. A lane whose enable is high keeps its previous contents.
- R7: A write command sampled at edge N makes dout_vld=0 after edge N+1.
- R8: A read command captured at the edge right after a write command to the same address returns the word that includes the newly written lanes.
- R9: When sleep=1 at an edge, the command presented at that edge is ignored, and dout_vld=0 after that edge, even if a read was pending. Stored words are unchanged by sleep.
- R10: A write accepted at edge N still samples din and updates the array at edge N+1, even when sleep=1 at edge N+1.
- R11: A write command with all bw_n bits high leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| sel_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write enable, meaningful when selected |
| bw_n | input | LANES (2) | Active-low byte-lane write enables |
| addr | input | clog2(DEPTH) (10) | Word address |
| din | input | LANES*LANE_W (18) | Write data, sampled one edge after the write command |
| oe_n | input | 1 | Active-low output enable |
| sleep | input | 1 | Active-high sleep |
| dout | output | LANES*LANE_W (18) | Read data, zero when not enabled |
| dout_en | output | 1 | Tri-state enable for dout |
| dout_vld | output | 1 | Output register holds valid read data |

## Verification
The properties assume that sel_n, we_n, sleep and oe_n are known and stable around every rising edge once reset is released. The read property also assumes sleep stays low on the edge after the read command. The stimulus drives all inputs only at falling clock edges. The latency check for reads is applied only where no sleep edge follows the read. Cases where sleep intervenes are covered by their own directed sequences.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Command decode at a rising edge; sleep forces no operation.
    function automatic op_e decode_op(input logic sel_n, input logic we_n, input logic sleep);
        op_e r;
        if (sleep || sel_n) r = OP_NONE;
        else if (we_n)      r = OP_READ;
        else                r = OP_WRITE;
        return r;
    endfunction

endpackage

// File: rtl/psr_cmd_stage.sv
module psr_cmd_stage
    import pipe_sram_pkg::*;
#(
    parameter int AW    = 10,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             we_n,
    input  logic             sleep,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] bw_n,
    output op_e              op_q,
    output logic [AW-1:0]    addr_q,
    output logic [LANES-1:0] lanes_q
);

    typedef struct packed {
        op_e              op;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] lanes;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d       = cmd_q;
        cmd_d.op    = decode_op(sel_n, we_n, sleep);
        cmd_d.addr  = addr;
        cmd_d.lanes = ~bw_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '{op: OP_NONE, addr: '0, lanes: '0};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign op_q    = cmd_q.op;
    assign addr_q  = cmd_q.addr;
    assign lanes_q = cmd_q.lanes;

endmodule

// File: rtl/psr_array.sv
module psr_array #(
    parameter int DEPTH  = 1024,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_lanes,
    input  logic [AW-1:0]    acc_addr,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
                mem_q[acc_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem_q[acc_addr];
    end

endmodule

// File: rtl/psr_out_stage.sv
module psr_out_stage #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         sleep,
    input  logic         oe_n,
    input  logic [W-1:0] rd_data,
    output logic [W-1:0] dout,
    output logic         dout_en,
    output logic         dout_vld
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = load && !sleep;
        if (load && !sleep) begin
            out_d.data = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{vld: 1'b0, data: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign dout_vld = out_q.vld;
    assign dout_en  = out_q.vld && !oe_n;
    assign dout     = dout_en ? out_q.data : '0;

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import pipe_sram_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             we_n,
    input  logic [LANES-1:0] bw_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     din,
    input  logic             oe_n,
    input  logic             sleep,
    output logic [W-1:0]     dout,
    output logic             dout_en,
    output logic             dout_vld
);

    op_e              op_q;
    logic [AW-1:0]    addr_q;
    logic [LANES-1:0] lanes_q;
    logic [W-1:0]     rd_data;

    psr_cmd_stage #(.AW(AW), .LANES(LANES)) i_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .we_n    (we_n),
        .sleep   (sleep),
        .addr    (addr),
        .bw_n    (bw_n),
        .op_q    (op_q),
        .addr_q  (addr_q),
        .lanes_q (lanes_q)
    );

    // A write accepted on the previous edge completes on this edge with
    // the data bus as it is now, independent of sleep.
    psr_array #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES)) i_array (
        .clk      (clk),
        .wr_en    (op_q == OP_WRITE),
        .wr_lanes (lanes_q),
        .acc_addr (addr_q),
        .wr_data  (din),
        .rd_data  (rd_data)
    );

    psr_out_stage #(.W(W)) i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (op_q == OP_READ),
        .sleep    (sleep),
        .oe_n     (oe_n),
        .rd_data  (rd_data),
        .dout     (dout),
        .dout_en  (dout_en),
        .dout_vld (dout_vld)
    );

endmodule

// File: rtl/psr_chk.sv
module psr_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sel_n,
    input logic         we_n,
    input logic         oe_n,
    input logic         sleep,
    input logic [W-1:0] dout,
    input logic         dout_en,
    input logic         dout_vld
);

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && we_n && !sleep) ##1 !sleep |=> dout_vld); // R2

    AST_DESEL_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> ##1 !dout_vld); // R3

    AST_EN_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (dout_vld && !oe_n)); // R4

    AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0)); // R4

    AST_WRITE_TURNS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !we_n) |=> ##1 !dout_vld); // R7

    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !dout_vld); // R9

endmodule

bind pipe_sram psr_chk #(.W(W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .dout     (dout),
    .dout_en  (dout_en),
    .dout_vld (dout_vld)
);

// File: tb/test_pipe_sram.sv
module test_pipe_sram;
    import pipe_sram_pkg::*;

    localparam int DEPTH  = 1024;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int AW     = $clog2(DEPTH);
    localparam int W      = LANE_W * LANES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sel_n = 1'b1;
    logic             we_n = 1'b1;
    logic [LANES-1:0] bw_n = '1;
    logic [AW-1:0]    addr = '0;
    logic [W-1:0]     din = '0;
    logic             oe_n = 1'b0;
    logic             sleep = 1'b0;
    logic [W-1:0]     dout;
    logic             dout_en;
    logic             dout_vld;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pipe_sram #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES)) i_pipe_sram (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .we_n(we_n), .bw_n(bw_n),
        .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
        .dout(dout), .dout_en(dout_en), .dout_vld(dout_vld)
    );

    typedef struct {
        logic         vld;
        logic [W-1:0] data;
        logic         oe;
        string        tag;
    } exp_t;

    exp_t         sb_q[$];
    logic [W-1:0] model [DEPTH];
    op_e          pend_op = OP_NONE;
    int           pend_a  = 0;
    logic [LANES-1:0] pend_bw = '1;

    function automatic logic [W-1:0] pat(input int x);
        return W'((x * 18'h0A5B) ^ 18'h15C3);
    endfunction

    task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: presents one command per clock and pushes the expected
    // outputs for the edge that follows.
    task automatic cyc(input op_e op, input int a, input logic [LANES-1:0] bw,
                       input logic [W-1:0] d, input logic oe, input logic slp, input string tag);
        exp_t e;
        @(negedge clk);
        sel_n = (op == OP_NONE);
        we_n  = (op != OP_WRITE);
        addr  = AW'(a);
        bw_n  = bw;
        din   = d;
        oe_n  = oe;
        sleep = slp;
        if (pend_op == OP_WRITE) begin
            for (int l = 0; l < LANES; l++)
                if (!pend_bw[l]) model[pend_a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
        end
        e.vld  = 1'b0;
        e.data = '0;
        if (!slp && pend_op == OP_READ) begin
            e.vld  = 1'b1;
            e.data = model[pend_a];
        end
        e.oe  = oe;
        e.tag = tag;
        sb_q.push_back(e);
        pend_op = slp ? OP_NONE : op;
        pend_a  = a;
        pend_bw = bw;
    endtask

    // Monitor: compares outputs shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, "dout_vld", W'(dout_vld), W'(e.vld));
                if (e.vld && !e.oe) begin
                    chk(e.tag, "dout_en", W'(dout_en), W'(1));
                    chk(e.tag, "dout", dout, e.data);
                end else begin
                    chk(e.tag, "dout_en", W'(dout_en), W'(0));
                    chk(e.tag, "dout", dout, '0);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1", "dout_vld in reset", W'(dout_vld), W'(0));
        chk("R1", "dout_en in reset", W'(dout_en), W'(0));
        chk("R1", "dout in reset", dout, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "dout_vld after reset", W'(dout_vld), W'(0));

        // R5: full-width late writes, data one clock behind the command
        for (int i = 0; i <= 8; i++)
            cyc(i < 8 ? OP_WRITE : OP_NONE, i, '0, pat(i - 1), 1'b0, 1'b0, "R7");
        // R2: back-to-back reads
        for (int i = 0; i <= 8; i++)
            cyc(i < 8 ? OP_READ : OP_NONE, i, '1, '0, 1'b0, 1'b0, "R2");

        // R3: output still valid one clock after deselect, then off
        cyc(OP_READ, 5, '1, '0, 1'b0, 1'b0, "R2");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b0, "R3");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b0, "R3");

        // R6 / R8: lane 0 only, read immediately after
        cyc(OP_WRITE, 3, 2'b10, '0, 1'b0, 1'b0, "R7");
        cyc(OP_READ, 3, '1, 18'h2AAAA, 1'b0, 1'b0, "R7");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b0, "R8");
        // R6: lane 1 only
        cyc(OP_WRITE, 4, 2'b01, '0, 1'b0, 1'b0, "R6");
        cyc(OP_READ, 4, '1, 18'h15555, 1'b0, 1'b0, "R6");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b0, "R6");
        // R11: no lanes enabled
        cyc(OP_WRITE, 6, 2'b11, '0, 1'b0, 1'b0, "R11");
        cyc(OP_READ, 6, '1, '1, 1'b0, 1'b0, "R11");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b0, "R11");

        // R4: output enable gating
        cyc(OP_READ, 2, '1, '0, 1'b0, 1'b0, "R4");
        cyc(OP_READ, 1, '1, '0, 1'b1, 1'b0, "R4");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b0, "R4");
        cyc(OP_NONE, 0, '1, '0, 1'b1, 1'b0, "R4");

        // R10 / R9: write completes under sleep, commands dropped
        cyc(OP_WRITE, 7, '0, '0, 1'b0, 1'b0, "R10");
        cyc(OP_READ, 7, '1, 18'h3C0F3, 1'b0, 1'b1, "R10");
        cyc(OP_READ, 1, '1, '0, 1'b0, 1'b1, "R9");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b0, "R9");
        cyc(OP_READ, 7, '1, '0, 1'b0, 1'b0, "R9");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b0, "R10");
        cyc(OP_READ, 1, '1, '0, 1'b0, 1'b0, "R9");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b1, "R9");
        cyc(OP_READ, 2, '1, '0, 1'b0, 1'b0, "R9");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b0, "R9");

        // R5: last address
        cyc(OP_WRITE, DEPTH - 1, '0, '0, 1'b0, 1'b0, "R5");
        cyc(OP_READ, DEPTH - 1, '1, 18'h2D2D2, 1'b0, 1'b0, "R5");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b0, "R5");
        cyc(OP_NONE, 0, '1, '0, 1'b0, 1'b0, "R3");

        @(posedge clk);
        #3;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule